// File: doc/BRIEF.md
# NAND Page Hamming ECC Accumulator

This block builds a Hamming-style error-correcting code over the bytes moving between a controller and a NAND flash array, one byte on every cycle in which `byte_valid` is high. For each byte it folds the data bits into even/odd column parity pairs chosen by bit position within the byte, and folds the byte parity into even/odd row parity pairs chosen by the bits of the byte's index inside the block. A block is either 256 or 512 bytes long, chosen by `mode_512`.

When the last byte of a block is accepted, the finished code is stored into the current slot of a bank of result registers, the accumulators restart, and the slot pointer moves to the next slot, wrapping after the last one. Software sees every slot at once on `slot_codes`. A clear strobe wipes all slots, drops any partial block and rewinds the pointer to the first slot; a separate strobe raises a one-cycle DMA request pulse.

Top module: `nand_ecc_accum`

## Requirements
- R1: Column pair j (j = 0, 1, 2, weights 1, 2, 4) accumulates in its odd half the XOR of every data bit whose bit index has bit j set, and in its even half the XOR of the data bits whose bit index has bit j clear, over all bytes of the block.
- R2: Row pair k (k = 0..8, weights 8 to 2048) accumulates the parity of each whole byte into its odd half when bit k of the byte index is 1, and into its even half when it is 0.
- R3: With `mode_512` low a block is 256 bytes and both halves of the weight-2048 pair are stored as 0; with `mode_512` high a block is 512 bytes and that pair is computed like the others. `mode_512` is held constant during a block.
- R4: Cycles with `byte_valid` low neither advance the byte index nor change the parities.
- R5: Each completed code is written to the current slot, and the slot pointer then advances to the next slot; after slot 8 it returns to slot 0.
- R6: A one-cycle `ecc_clear` strobe clears every slot to 0 in the second clock edge after it, discards any partial block, and sends the next completed code to slot 0.
- R7: After reset every slot reads 0 and `dma_req` is low.
- R8: A one-cycle `dma_kick` strobe makes `dma_req` high for exactly the following cycle; it then returns low by itself.
- R9: A code is 24 bits: bits [11:0] hold the even halves and bits [23:12] the odd halves, each ordered by weight 1, 2, 4, 8, ..., 2048 from the low bit (weight-1 even at bit 0, weight-16 even at bit 4); slot n sits at `slot_codes[24*n +: 24]` and shows the new code from the clock edge that accepts the block's last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_512 | input | 1 | Block length select: 0 = 256 bytes, 1 = 512 bytes |
| byte_valid | input | 1 | Byte on `byte_data` is accepted this cycle |
| byte_data | input | 8 | Data byte |
| ecc_clear | input | 1 | Write strobe of the self-clearing slot clear bit |
| dma_kick | input | 1 | Write strobe of the self-clearing DMA request bit |
| dma_req | output | 1 | DMA request pulse |
| slot_codes | output | 216 | All nine result slots, slot n at bits [24*n +: 24] |

## Verification
A wrong byte index or a parity routed to the wrong half shows up as a wrong bit pair in the slot written at the block's last byte, so single-bit blocks swept across many byte and bit positions point each fault to one pair at the edge that completes the block. A pointer that skips, fails to wrap or is not rewound by the clear puts a correct code in the wrong slot, visible in the full slot compare made after every block. Idle cycles inserted between bytes carry junk data, so a parity that ignores `byte_valid` corrupts the very next stored code.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int BYTE_W    = 8;
  localparam int COL_PAIRS = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // Bits of a byte whose bit index has address bit j set.
  function automatic byte_t odd_mask(input int j);
    byte_t m;
    for (int b = 0; b < BYTE_W; b++) begin
      m[b] = ((b >> j) & 1) == 1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_col_parity.sv
module ecc_col_parity
  import nand_ecc_pkg::*;
(
  input  byte_t                data,
  output logic [COL_PAIRS-1:0] col_e,
  output logic [COL_PAIRS-1:0] col_o,
  output logic                 byte_par
);

  for (genvar j = 0; j < COL_PAIRS; j++) begin : g_col
    localparam byte_t MASK = odd_mask(j);
    assign col_o[j] = ^(data & MASK);
    assign col_e[j] = ^(data & ~MASK);
  end

  assign byte_par = ^data;

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int ROW_BITS = 9,
  localparam int PAIRS   = COL_PAIRS + ROW_BITS,
  localparam int CODE_W  = 2 * PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wide,
  input  logic              valid,
  input  byte_t             data,
  output logic              done,
  output logic [CODE_W-1:0] code
);

  logic [PAIRS-1:0]     even_q, odd_q;
  logic [PAIRS-1:0]     add_e, add_o;
  logic [PAIRS-1:0]     nxt_e, nxt_o;
  logic [ROW_BITS-1:0]  idx_q;
  logic [COL_PAIRS-1:0] col_e, col_o;
  logic                 byte_par;
  logic                 last;

  ecc_col_parity u_col (
    .data     (data),
    .col_e    (col_e),
    .col_o    (col_o),
    .byte_par (byte_par)
  );

  assign add_e[COL_PAIRS-1:0] = col_e;
  assign add_o[COL_PAIRS-1:0] = col_o;

  for (genvar k = 0; k < ROW_BITS; k++) begin : g_row
    assign add_e[COL_PAIRS+k] = byte_par & ~idx_q[k];
    assign add_o[COL_PAIRS+k] = byte_par &  idx_q[k];
  end

  assign nxt_e = valid ? (even_q ^ add_e) : even_q;
  assign nxt_o = valid ? (odd_q  ^ add_o) : odd_q;

  always_comb begin
    if (wide) last = valid && (idx_q == '1);
    else      last = valid && (idx_q[ROW_BITS-2:0] == '1);
  end

  assign done = last && !flush;

  // Short blocks never own the top row pair: force both halves to zero.
  always_comb begin
    code = {nxt_o, nxt_e};
    if (!wide) begin
      code[PAIRS-1]        = 1'b0;
      code[CODE_W-1]       = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush || last) begin
      even_q <= '0;
      odd_q  <= '0;
      idx_q  <= '0;
    end else if (valid) begin
      even_q <= nxt_e;
      odd_q  <= nxt_o;
      idx_q  <= idx_q + 1'b1;
    end
  end

  // Every pair's halves together cover all bits once, so even^odd is the
  // same total parity for every pair at block end.
  logic [PAIRS-1:0] pair_sum;
  assign pair_sum = nxt_e ^ nxt_o;

  assert_pair_balance_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (pair_sum == '0 || pair_sum == '1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!valid && !flush) |=> (idx_q == $past(idx_q) && even_q == $past(even_q)));

endmodule

// File: rtl/ecc_slot_bank.sv
module ecc_slot_bank #(
  parameter int NUM_SLOTS = 9,
  parameter int CODE_W    = 24,
  parameter int PAIRS     = CODE_W / 2,
  localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        narrow,
  input  logic                        wr_en,
  input  logic [CODE_W-1:0]           wr_data,
  output logic [NUM_SLOTS*CODE_W-1:0] slots_flat
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_SLOTS - 1);

  logic [CODE_W-1:0] slot_q [NUM_SLOTS];
  logic [PTR_W-1:0]  ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
    end else if (wr_en) begin
      slot_q[ptr_q] <= wr_data;
      ptr_q         <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_out
    assign slots_flat[n*CODE_W +: CODE_W] = slot_q[n];
  end

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST_SLOT);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=>
      ptr_q == (($past(ptr_q) == LAST_SLOT) ? '0 : $past(ptr_q) + 1'b1));

  assert_clear_rewind_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr_q == '0));

  assert_short_top_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && narrow) |-> (wr_data[PAIRS-1] == 1'b0 && wr_data[CODE_W-1] == 1'b0));

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  parameter int MAX_BLOCK = 512,
  localparam int ROW_BITS = $clog2(MAX_BLOCK),
  localparam int PAIRS    = COL_PAIRS + ROW_BITS,
  localparam int CODE_W   = 2 * PAIRS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        mode_512,
  input  logic                        byte_valid,
  input  logic [BYTE_W-1:0]           byte_data,
  input  logic                        ecc_clear,
  input  logic                        dma_kick,
  output logic                        dma_req,
  output logic [NUM_SLOTS*CODE_W-1:0] slot_codes
);

  logic              clr_q;
  logic              dma_q;
  logic              blk_done;
  logic [CODE_W-1:0] blk_code;

  // Self-clearing control bits: set by a write strobe, gone one cycle later.
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      clr_q <= ecc_clear;
      dma_q <= dma_kick;
    end
  end

  assign dma_req = dma_q;

  ecc_accum #(.ROW_BITS(ROW_BITS)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .flush (clr_q),
    .wide  (mode_512),
    .valid (byte_valid),
    .data  (byte_data),
    .done  (blk_done),
    .code  (blk_code)
  );

  ecc_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .PAIRS(PAIRS)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .clear      (clr_q),
    .narrow     (!mode_512),
    .wr_en      (blk_done),
    .wr_data    (blk_code),
    .slots_flat (slot_codes)
  );

  assert_clear_wipes_R6: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (slot_codes == '0));

  assert_dma_single_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_kick) |=> !dma_req);

  assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slot_codes == '0 && !dma_req));

endmodule

// File: tb/nand_ecc_accum_test.sv
module nand_ecc_accum_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 9;
  localparam int CW   = 24;
  localparam int FLAT = NS * CW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode_512 = 1'b0;
  logic            byte_valid = 1'b0;
  logic [7:0]      byte_data = 8'h00;
  logic            ecc_clear = 1'b0;
  logic            dma_kick = 1'b0;
  logic            dma_req;
  logic [FLAT-1:0] slot_codes;

  int errors = 0;
  int checks = 0;

  logic [7:0]    mem [512];
  logic [CW-1:0] exp_slot [NS];
  int            exp_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_accum uut (
    .clk        (clk),
    .rst        (rst),
    .mode_512   (mode_512),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .ecc_clear  (ecc_clear),
    .dma_kick   (dma_kick),
    .dma_req    (dma_req),
    .slot_codes (slot_codes)
  );

  task automatic chk(input string req, input logic [FLAT-1:0] act, input logic [FLAT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected code from R1, R2, R3, R9: even halves in [11:0], odd in [23:12].
  function automatic logic [CW-1:0] model_code(input bit wide);
    logic [11:0] e = '0;
    logic [11:0] o = '0;
    int n = wide ? 512 : 256;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (mem[i][b]) begin
          for (int j = 0; j < 3; j++) begin
            if ((b >> j) & 1) o[j] = ~o[j]; else e[j] = ~e[j];
          end
          for (int k = 0; k < 9; k++) begin
            if ((i >> k) & 1) o[3+k] = ~o[3+k]; else e[3+k] = ~e[3+k];
          end
        end
      end
    end
    if (!wide) begin
      e[11] = 1'b0;
      o[11] = 1'b0;
    end
    return {o, e};
  endfunction

  function automatic logic [FLAT-1:0] exp_flat();
    logic [FLAT-1:0] f;
    for (int s = 0; s < NS; s++) f[s*CW +: CW] = exp_slot[s];
    return f;
  endfunction

  task automatic fill(input int kind, input int seed);
    for (int i = 0; i < 512; i++) begin
      case (kind)
        0: mem[i] = 8'h00;
        1: mem[i] = 8'hFF;
        2: mem[i] = 8'((i & 255) ^ seed);
        3: mem[i] = 8'h00;
        default: mem[i] = 8'(i * 73 + seed * 29 + (i >> 3));
      endcase
    end
    if (kind == 3) mem[(seed >> 3) % 512][seed & 7] = 1'b1;
  endtask

  // Streams one block; every gap-th byte is preceded by an idle junk cycle (R4).
  task automatic run_block(input bit wide, input int gap, input string req);
    int n = wide ? 512 : 256;
    mode_512 = wide;
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == 0) begin
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'(i ^ 8'h5A);
      end
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = mem[i];
    end
    @(negedge clk);
    byte_valid = 1'b0;
    byte_data  = 8'hC3;
    exp_slot[exp_ptr] = model_code(wide);
    exp_ptr = (exp_ptr + 1) % NS;
    chk(req, slot_codes, exp_flat());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) exp_slot[s] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 slots after reset", slot_codes, '0);
    chk("R7 dma_req after reset", FLAT'(dma_req), '0);

    // R8 DMA pulse
    dma_kick = 1'b1;
    @(negedge clk);
    dma_kick = 1'b0;
    chk("R8 dma_req raised", FLAT'(dma_req), FLAT'(1));
    @(negedge clk);
    chk("R8 dma_req self-clears", FLAT'(dma_req), '0);

    // Short-mode blocks with various patterns, wrapping the slots (R5)
    fill(0, 0); run_block(1'b0, 0, "R9 zero block");
    fill(1, 0); run_block(1'b0, 7, "R1 R2 all-ones block R4");
    fill(2, 8'h3C); run_block(1'b0, 5, "R2 index pattern R4");
    fill(4, 11); run_block(1'b0, 3, "R1 mixed pattern R4");
    for (int s = 0; s < 48; s++) begin
      fill(3, (s * 173 + 5) % 2048);
      run_block(1'b0, (s % 4 == 0) ? 9 : 0, "R1 R2 R5 single-bit short");
    end

    // Long-mode blocks: top pair live (R3)
    fill(1, 0); run_block(1'b1, 0, "R3 all-ones long");
    fill(4, 77); run_block(1'b1, 11, "R3 mixed long R4");
    for (int s = 0; s < 24; s++) begin
      fill(3, 2048 + (s * 211 + 3) % 2048);
      run_block(1'b1, 0, "R3 R2 single-bit long");
    end
    fill(3, 256 * 8 + 5); run_block(1'b0, 0, "R3 short ignores top pair");

    // R6 clear mid-block
    fill(4, 3);
    mode_512 = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = mem[i];
    end
    @(negedge clk);
    byte_valid = 1'b0;
    ecc_clear  = 1'b1;
    @(negedge clk);
    ecc_clear = 1'b0;
    @(negedge clk);
    chk("R6 slots cleared", slot_codes, '0);
    for (int s = 0; s < NS; s++) exp_slot[s] = '0;
    exp_ptr = 0;
    fill(2, 8'h91); run_block(1'b0, 0, "R6 next code in slot 0");
    fill(4, 19); run_block(1'b1, 6, "R6 R5 following slot");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule